// File: doc/BRIEF.md
# Per-Channel Hit Timestamp Latch

This block gives every channel of a multi-channel detector front end its own coarse arrival time, taken before the channels are funnelled onto one serial line. A phase divider splits the 32 MHz readout clock by eight into a 4 MHz count enable. An 8-bit coarse counter advances on that enable. Two external lines keep many such chips on one common timebase. One line zeroes the counter and the other realigns the divider phase. Hits are one-cycle pulses from each channel's discriminator. On a hit, the count in force is frozen into that channel's register and the channel is marked as holding data.

A read request takes a snapshot of the marked channels. The block then sends one 15-bit word per marked channel, lowest channel first, on a single serial output. A strobe flags the first bit of each word. Channels that saw no hit cost no time on the line. Off-chip logic rebuilds the full time from the coarse value and the read context.

Top module: `chan_ts_latch`

## Requirements
- R1: While reset is asserted and after it is released, `ser_out` and `frame_strb` are low and no channel holds data, so a read request sends no words.
- R2: When no clear or synch is applied, the count rises by one every 8 clocks. The phase is counted from the last clear or synch edge, so the first step comes at the eighth edge after it. The count wraps from 255 to 0.
- R3: `ts_clear` sampled high sets both the count and the divider phase to zero. It wins over `ts_sync` and over a due step in the same cycle.
- R4: `ts_sync` sampled high without `ts_clear` sets the divider phase to zero and keeps the count. A step that was due in that cycle is suppressed.
- R5: `hit[i]` sampled high at an edge stores, for channel i, the count held just before that edge, and marks the channel as holding data.
- R6: A hit on a channel that already holds data has no effect. Its stored time stays that of the first hit.
- R7: A read request sent while idle sends exactly the channels marked at the request edge, in ascending channel order.
- R8: Each word is 15 bits, MSB first: the 7-bit channel number followed by the 8-bit stored count. `frame_strb` is high only during the first bit of a word. `ser_out` is low whenever no word is being sent.
- R9: Once a channel's word has started, the channel is unmarked. A later hit on it is captured fresh, and a second read with no new hits sends nothing.
- R10: A read request that arrives while a readout is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz readout clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_clear | input | 1 | Zeroes the coarse count and divider phase |
| ts_sync | input | 1 | Realigns the divider phase to this edge |
| hit | input | 128 | One-cycle discriminator pulses, one per channel |
| rd_req | input | 1 | Starts a readout of all marked channels |
| ser_out | output | 1 | Serial word data, MSB first |
| frame_strb | output | 1 | High on the first bit of each word |

## Verification
The hardest case to reach is a hit that lands on a channel after its word has started but while other words are still in flight. A read request given at that moment must be ignored, while the hit must still be kept for the next frame. The bench gets there by marking two channels and collecting the first word. On the edge right after that word's last bit, it pulses both the channel's hit and a read request. It then checks that the second word arrives, that nothing follows it, and that a fresh read returns the re-hit time. The same bench holds a model of the divider and counter. This model lets it apply `ts_sync` exactly on the cycle where a step is due.

// File: rtl/chts_pkg.sv
package chts_pkg;
  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_LOAD  = 2'd1,
    SER_SHIFT = 2'd2
  } ser_state_e;
endpackage

// File: rtl/chts_rst_sync.sv
module chts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/chts_timebase.sv
module chts_timebase #(
  parameter int TS_W = 8,
  parameter int DIV  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ts_clear,
  input  logic                     ts_sync,
  output logic [TS_W-1:0]          count_o,
  output logic [$clog2(DIV)-1:0]   phase_o,
  output logic                     tick_o
);
  localparam int PH_W = $clog2(DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [TS_W-1:0] cnt_q, cnt_d;
  logic            ph_en, cnt_en;
  logic            tick;

  assign tick = (ph_q == PH_LAST);

  // next state: clear > sync > step
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    ph_en  = 1'b1;
    cnt_en = 1'b0;
    if (ts_clear) begin
      ph_d   = '0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (ts_sync) begin
      ph_d   = '0;
    end else if (tick) begin
      ph_d   = '0;
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else begin
      ph_d   = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign phase_o = ph_q;
  assign tick_o  = tick;
endmodule

// File: rtl/chts_hit_bank.sv
module chts_hit_bank #(
  parameter int NUM_CH = 128,
  parameter int TS_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        hit_i,
  input  logic [NUM_CH-1:0]        unload_i,
  input  logic [TS_W-1:0]          count_i,
  output logic [NUM_CH-1:0]        valid_o,
  output logic [NUM_CH*TS_W-1:0]   ts_flat_o
);
  logic [NUM_CH-1:0] valid_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic            cap;
    logic            valid_d;
    logic [TS_W-1:0] ts_q;

    // a hit is taken when the channel is empty or is being unloaded now
    assign cap     = hit_i[g] & (~valid_q[g] | unload_i[g]);
    assign valid_d = cap | (valid_q[g] & ~unload_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else begin
        valid_q[g] <= valid_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ts_q <= '0;
      end else if (cap) begin
        ts_q <= count_i;
      end
    end

    assign ts_flat_o[g*TS_W +: TS_W] = ts_q;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/chts_serializer.sv
module chts_serializer
  import chts_pkg::*;
#(
  parameter int NUM_CH = 128,
  parameter int TS_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req_i,
  input  logic [NUM_CH-1:0]        valid_i,
  input  logic [NUM_CH*TS_W-1:0]   ts_flat_i,
  output logic [NUM_CH-1:0]        unload_o,
  output logic [NUM_CH-1:0]        pend_o,
  output logic                     busy_o,
  output logic                     ser_o,
  output logic                     frame_o
);
  localparam int IDX_W  = $clog2(NUM_CH);
  localparam int WORD_W = IDX_W + TS_W;
  localparam int BC_W   = $clog2(WORD_W);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_W - 1);

  ser_state_e        state_q, state_d;
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic              pend_any;
  logic [IDX_W-1:0]  sel_idx;
  logic [TS_W-1:0]   sel_ts;

  assign pend_any = |pend_q;

  // lowest pending channel
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_q[i]) sel_idx = IDX_W'(i);
    end
  end

  assign sel_ts = ts_flat_i[sel_idx*TS_W +: TS_W];

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    sh_d     = sh_q;
    bc_d     = bc_q;
    unload_o = '0;
    unique case (state_q)
      SER_IDLE: begin
        if (rd_req_i) begin
          pend_d  = valid_i;
          state_d = SER_LOAD;
        end
      end
      SER_LOAD: begin
        if (!pend_any) begin
          state_d = SER_IDLE;
        end else begin
          sh_d              = {sel_idx, sel_ts};
          bc_d              = '0;
          pend_d[sel_idx]   = 1'b0;
          unload_o[sel_idx] = 1'b1;
          state_d           = SER_SHIFT;
        end
      end
      SER_SHIFT: begin
        sh_d = {sh_q[WORD_W-2:0], 1'b0};
        bc_d = bc_q + 1'b1;
        if (bc_q == BC_LAST) state_d = SER_LOAD;
      end
      default: state_d = SER_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      pend_q  <= '0;
      sh_q    <= '0;
      bc_q    <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      sh_q    <= sh_d;
      bc_q    <= bc_d;
    end
  end

  assign busy_o  = (state_q != SER_IDLE);
  assign ser_o   = (state_q == SER_SHIFT) & sh_q[WORD_W-1];
  assign frame_o = (state_q == SER_SHIFT) & (bc_q == '0);
  assign pend_o  = pend_q;
endmodule

// File: rtl/chan_ts_latch.sv
module chan_ts_latch #(
  parameter int NUM_CH = 128,
  parameter int TS_W   = 8,
  parameter int DIV    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_clear,
  input  logic              ts_sync,
  input  logic [NUM_CH-1:0] hit,
  input  logic              rd_req,
  output logic              ser_out,
  output logic              frame_strb
);
  localparam int PH_W = $clog2(DIV);

  logic                   rst_sync_n;
  logic [TS_W-1:0]        count;
  logic [PH_W-1:0]        phase;
  logic                   tick;
  logic [NUM_CH-1:0]      valid;
  logic [NUM_CH-1:0]      unload;
  logic [NUM_CH-1:0]      pend;
  logic [NUM_CH*TS_W-1:0] ts_flat;
  logic                   busy;

  chts_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  chts_timebase #(.TS_W(TS_W), .DIV(DIV)) u_tb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ts_clear (ts_clear),
    .ts_sync  (ts_sync),
    .count_o  (count),
    .phase_o  (phase),
    .tick_o   (tick)
  );

  chts_hit_bank #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hit_i     (hit),
    .unload_i  (unload),
    .count_i   (count),
    .valid_o   (valid),
    .ts_flat_o (ts_flat)
  );

  chts_serializer #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_req_i  (rd_req),
    .valid_i   (valid),
    .ts_flat_i (ts_flat),
    .unload_o  (unload),
    .pend_o    (pend),
    .busy_o    (busy),
    .ser_o     (ser_out),
    .frame_o   (frame_strb)
  );
endmodule

// File: rtl/chts_checker.sv
module chts_checker #(
  parameter int NUM_CH = 128,
  parameter int TS_W   = 8,
  parameter int DIV    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ts_clear,
  input logic                     ts_sync,
  input logic                     rd_req,
  input logic [TS_W-1:0]          count,
  input logic [$clog2(DIV)-1:0]   phase,
  input logic                     tick,
  input logic                     busy,
  input logic [NUM_CH-1:0]        pend,
  input logic                     ser_out,
  input logic                     frame_strb
);
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clear |=> (count == '0) && (phase == '0));

  p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_sync && !ts_clear) |=> (phase == '0) && (count == $past(count)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ts_clear && !ts_sync) |=> (count == TS_W'($past(count) + 1'b1)));

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ts_clear) |=> $stable(count));

  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strb |=> !frame_strb);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!frame_strb && !ser_out));

  p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_req) |=> ((pend & ~$past(pend)) == '0));
endmodule

bind chan_ts_latch chts_checker #(.NUM_CH(NUM_CH), .TS_W(TS_W), .DIV(DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ts_clear   (ts_clear),
  .ts_sync    (ts_sync),
  .rd_req     (rd_req),
  .count      (count),
  .phase      (phase),
  .tick       (tick),
  .busy       (busy),
  .pend       (pend),
  .ser_out    (ser_out),
  .frame_strb (frame_strb)
);

// File: tb/chan_ts_latch_tb.sv
module chan_ts_latch_tb;
  localparam int NUM_CH = 128;
  localparam int TS_W   = 8;
  localparam int IDX_W  = 7;
  localparam int WORD_W = IDX_W + TS_W;

  logic              clk;
  logic              rst_n;
  logic              ts_clear;
  logic              ts_sync;
  logic [NUM_CH-1:0] hit;
  logic              rd_req;
  logic              ser_out;
  logic              frame_strb;

  int checks;
  int failures;

  // reference model built from the requirements
  logic [NUM_CH-1:0] m_valid;
  logic [TS_W-1:0]   m_ts [NUM_CH];
  logic [TS_W-1:0]   m_cnt;
  int                m_ph;

  chan_ts_latch u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts_clear   (ts_clear),
    .ts_sync    (ts_sync),
    .hit        (hit),
    .rd_req     (rd_req),
    .ser_out    (ser_out),
    .frame_strb (frame_strb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i] && !m_valid[i]) begin
        m_valid[i] = 1'b1;
        m_ts[i]    = m_cnt;
      end
    end
    if (ts_clear) begin
      m_ph = 0; m_cnt = '0;
    end else if (ts_sync) begin
      m_ph = 0;
    end else if (m_ph == 7) begin
      m_ph = 0; m_cnt = m_cnt + 1'b1;
    end else begin
      m_ph = m_ph + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_hit(input int ch);
    hit[ch] = 1'b1;
    @(negedge clk);
    hit = '0;
  endtask

  task automatic get_word(input int timeout, output bit found, output logic [WORD_W-1:0] w);
    found = 1'b0;
    w = '0;
    for (int t = 0; t < timeout; t++) begin
      @(negedge clk);
      if (frame_strb) begin
        found = 1'b1;
        w[WORD_W-1] = ser_out;
        for (int b = WORD_W - 2; b >= 0; b--) begin
          @(negedge clk);
          w[b] = ser_out;
          chk(!frame_strb, "R8 strobe only on first bit", 1, 0);
        end
        return;
      end
    end
  endtask

  task automatic expect_words(input logic [NUM_CH-1:0] exp, input string req);
    bit found;
    logic [WORD_W-1:0] w;
    for (int c = 0; c < NUM_CH; c++) begin
      if (exp[c]) begin
        get_word(64, found, w);
        chk(found, {req, " word present"}, found, 1);
        chk(w == {IDX_W'(c), m_ts[c]}, {req, " word content"}, w, {IDX_W'(c), m_ts[c]});
      end
    end
    get_word(40, found, w);
    chk(!found, {req, " no extra word"}, found, 0);
    chk(!ser_out && !frame_strb, "R8 line quiet after frame", {ser_out, frame_strb}, 0);
  endtask

  task automatic do_read(input string req);
    logic [NUM_CH-1:0] exp;
    exp = m_valid;
    m_valid = '0;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    expect_words(exp, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit found;
    logic [WORD_W-1:0] w;
    logic [NUM_CH-1:0] exp;
    checks = 0; failures = 0;
    rst_n = 1'b0; ts_clear = 1'b0; ts_sync = 1'b0; hit = '0; rd_req = 1'b0;
    m_valid = '0; m_cnt = '0; m_ph = 0;
    for (int i = 0; i < NUM_CH; i++) m_ts[i] = '0;
    idle(3);
    // R1: reset state
    chk(!ser_out && !frame_strb, "R1 outputs low in reset", {ser_out, frame_strb}, 0);
    rst_n = 1'b1;
    idle(4);
    chk(!ser_out && !frame_strb, "R1 outputs low after reset", {ser_out, frame_strb}, 0);
    do_read("R1 empty after reset");

    // align timebase
    ts_clear = 1'b1; @(negedge clk); ts_clear = 1'b0;

    // R5/R7: scattered hits, edge channels
    idle(13); pulse_hit(127);
    idle(40); pulse_hit(0);
    idle(1);  pulse_hit(64);
    idle(100); pulse_hit(3);
    do_read("R5 R7 scattered hits");

    // R6: second hit ignored
    pulse_hit(10);
    idle(50); pulse_hit(10);
    idle(9);  pulse_hit(11);
    do_read("R6 second hit ignored");

    // R2: wrap past 255
    idle(2100); pulse_hit(20);
    idle(7);    pulse_hit(21);
    do_read("R2 wrap");

    // R4: sync on a due step, then observe
    while (m_ph != 7) @(negedge clk);
    ts_sync = 1'b1; @(negedge clk); ts_sync = 1'b0;
    pulse_hit(30);
    idle(6); pulse_hit(31);
    idle(0); pulse_hit(32);
    idle(3); ts_sync = 1'b1; @(negedge clk); ts_sync = 1'b0;
    idle(7); pulse_hit(33);
    pulse_hit(34);
    do_read("R4 sync");

    // R3: clear and sync together, clear wins
    idle(37);
    ts_clear = 1'b1; ts_sync = 1'b1; @(negedge clk); ts_clear = 1'b0; ts_sync = 1'b0;
    idle(6); pulse_hit(50);
    pulse_hit(51);
    idle(12); pulse_hit(52);
    do_read("R3 clear over sync");

    // R9/R10: re-hit after unload, request during busy ignored
    pulse_hit(40);
    idle(5); pulse_hit(41);
    exp = m_valid; m_valid = '0;
    rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    get_word(64, found, w);
    chk(found && w == {IDX_W'(40), m_ts[40]}, "R7 first word", w, {IDX_W'(40), m_ts[40]});
    hit[40] = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    hit = '0; rd_req = 1'b0;
    exp[40] = 1'b0;
    expect_words(exp, "R10 busy request ignored");
    chk(m_valid == (NUM_CH'(1) << 40), "R9 model re-hit taken", m_valid, NUM_CH'(1) << 40);
    do_read("R9 re-hit captured fresh");
    do_read("R9 second read empty");

    // R8/R5: sweep every channel, one per cycle
    for (int i = 0; i < NUM_CH; i++) begin
      hit[i] = 1'b1; @(negedge clk); hit = '0;
    end
    do_read("R8 full sweep");

    // all channels in one cycle
    idle(19);
    hit = '1; @(negedge clk); hit = '0;
    do_read("R5 simultaneous hits");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule